// File: doc/BRIEF.md
# Predicated Step Sequencer

This block produces the element schedule for a vector loop governed by one predicate mask. A start pulse captures a vector length, a mask and two zeroing flags, one for the source side and one for the destination side. From then on the block presents one (source index, destination index) pair per cycle on a valid/ready stream, until one of the two sides runs out of positions below the vector length.

Both sides read the same mask, but each side walks its own index. A side whose zeroing flag is clear steps over every position whose mask bit is 0. A side whose flag is set visits every position and marks the masked-out ones with a zero flag, so the consumer writes or reads a zero there. When the two flags differ, the two indices drift apart. When they are equal, the two indices stay in lockstep. When no predicate is in use, the mask counts as all ones. A shared zeroing control is expressed by driving both flags to the same value.

The output stream follows valid/ready rules. A pair is consumed on a cycle where `out_valid` and `out_ready` are both high. While `out_ready` is low, the pair and its zero flags hold unchanged. The block never withdraws a valid pair before it is accepted. `done` is a plain one-cycle status pulse and needs no acknowledge.

Top module: `step_seq`

## Requirements
- R1: During and right after reset, `out_valid` and `done` are low.
- R2: `start` captures `vl_in`, `mask_in`, `pred_en`, `sz` and `dz`. Later changes on these inputs have no effect on the running sequence.
- R3: Each accepted pair advances both sides. Until the sequence ends, a valid pair is presented in every cycle, and each pair has strictly larger source and destination indices than the pair before it.
- R4: A side whose zeroing flag is 0 visits, in ascending order, exactly the positions below the vector length whose mask bit is 1. The source side uses `sz` and the destination side uses `dz`.
- R5: A side whose zeroing flag is 1 visits every position below the vector length in ascending order. Its flag (`zero_src` or `zero_dst`) is 1 exactly when the mask bit at its index is 0.
- R6: With `pred_en` = 0, the mask is taken as all ones and `mask_in` is ignored.
- R7: The sequence ends as soon as either side has no position left below the vector length. In that cycle `done` is high for one cycle and `out_valid` is low. A vector length of 0 gives `done` in the first cycle after start, with no pairs.
- R8: While `out_valid` is high and `out_ready` is low, the next cycle shows the same pair with `out_valid` still high.
- R9: When `sz` equals `dz`, every presented pair has equal source and destination indices.
- R10: `start` is accepted when the block is idle or in its `done` cycle. In the `done` case, the first pair of the new sequence appears in the next cycle. At any other time `start` is ignored.
- R11: A `vl_in` value above `MAX_VL` is treated as `MAX_VL`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Captures the configuration and begins a sequence |
| vl_in | input | LEN_W | Vector length, 0 to MAX_VL |
| pred_en | input | 1 | 1: use mask_in; 0: all positions active |
| mask_in | input | MAX_VL | Predicate mask, bit i for position i |
| sz | input | 1 | Source side zeroing (1: do not skip masked-out positions) |
| dz | input | 1 | Destination side zeroing (1: do not skip masked-out positions) |
| out_valid | output | 1 | A step pair is presented |
| out_ready | input | 1 | Consumer accepts the presented pair |
| src_step | output | IDX_W | Source element index |
| dst_step | output | IDX_W | Destination element index |
| zero_src | output | 1 | Source position is masked out and not skipped |
| zero_dst | output | 1 | Destination position is masked out and not skipped |
| done | output | 1 | One-cycle end-of-sequence pulse |

## Verification
Two events can fall in the same cycle: the end-of-sequence pulse and the acceptance of a new start. The bench raises `start` with a fresh configuration in exactly the cycle where `done` is high. It then requires the new sequence's first pair in the next cycle, with no idle gap and no second `done`. A second case makes the start pulse coincide with a stalled valid pair instead. In that case the start must be dropped, and the stalled pair and the rest of the old sequence must come out unchanged.

// File: rtl/step_seq_pkg.sv
package step_seq_pkg;

  // Limit a requested length to the configured capacity.
  function automatic int unsigned fit_len(input int unsigned req, input int unsigned cap);
    return (req > cap) ? cap : req;
  endfunction

  // Index of the two walkers inside the sequencer.
  localparam int unsigned SIDE_SRC = 0;
  localparam int unsigned SIDE_DST = 1;
  localparam int unsigned SIDE_CNT = 2;

endpackage

// File: rtl/step_finder.sv
module step_finder #(
  parameter int unsigned MAX_VL = 64,
  parameter int unsigned IDX_W  = $clog2(MAX_VL),
  parameter int unsigned LEN_W  = $clog2(MAX_VL + 1)
) (
  input  logic [MAX_VL-1:0] elig,
  input  logic [LEN_W-1:0]  vl,
  input  logic [LEN_W-1:0]  base,
  output logic              found,
  output logic [IDX_W-1:0]  pos
);
  logic [MAX_VL-1:0] cand;

  // One candidate flag per position: eligible, inside the length, at or after base.
  for (genvar i = 0; i < MAX_VL; i++) begin : g_cand
    assign cand[i] = elig[i] && (LEN_W'(i) < vl) && (LEN_W'(i) >= base);
  end

  // Lowest candidate wins.
  always_comb begin
    pos = '0;
    for (int i = MAX_VL - 1; i >= 0; i--) begin
      if (cand[i]) pos = IDX_W'(i);
    end
  end

  assign found = |cand;
endmodule

// File: rtl/step_side.sv
module step_side #(
  parameter int unsigned MAX_VL = 64,
  parameter int unsigned IDX_W  = $clog2(MAX_VL),
  parameter int unsigned LEN_W  = $clog2(MAX_VL + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              advance,
  input  logic              keep,
  input  logic [MAX_VL-1:0] mask,
  input  logic [LEN_W-1:0]  vl,
  output logic              found,
  output logic [IDX_W-1:0]  pos,
  output logic              zero
);
  logic [LEN_W-1:0]  base_q;
  logic [MAX_VL-1:0] elig;

  // A side that keeps masked-out slots treats every slot as eligible.
  assign elig = keep ? {MAX_VL{1'b1}} : mask;

  step_finder #(.MAX_VL(MAX_VL), .IDX_W(IDX_W), .LEN_W(LEN_W)) u_find (
    .elig  (elig),
    .vl    (vl),
    .base  (base_q),
    .found (found),
    .pos   (pos)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       base_q <= '0;
    else if (load)    base_q <= '0;
    else if (advance) base_q <= LEN_W'(pos) + LEN_W'(1);
  end

  assign zero = keep && !mask[pos];

  // R4
  skip_only_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (found && !keep) |-> mask[pos]);

  // R7
  pos_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> (LEN_W'(pos) < vl));
endmodule

// File: rtl/step_seq.sv
module step_seq #(
  parameter int unsigned MAX_VL = 64,
  localparam int unsigned IDX_W = $clog2(MAX_VL),
  localparam int unsigned LEN_W = $clog2(MAX_VL + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [LEN_W-1:0]  vl_in,
  input  logic              pred_en,
  input  logic [MAX_VL-1:0] mask_in,
  input  logic              sz,
  input  logic              dz,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [IDX_W-1:0]  src_step,
  output logic [IDX_W-1:0]  dst_step,
  output logic              zero_src,
  output logic              zero_dst,
  output logic              done
);
  import step_seq_pkg::*;

  logic              active_q;
  logic [LEN_W-1:0]  vl_q;
  logic [MAX_VL-1:0] mask_q;
  logic              sz_q, dz_q;

  logic [SIDE_CNT-1:0] keep_v, found_v, zero_v;
  logic [IDX_W-1:0]    pos_v [SIDE_CNT];

  logic both_found, accept, fire;

  assign keep_v[SIDE_SRC] = sz_q;
  assign keep_v[SIDE_DST] = dz_q;

  for (genvar s = 0; s < SIDE_CNT; s++) begin : g_side
    step_side #(.MAX_VL(MAX_VL), .IDX_W(IDX_W), .LEN_W(LEN_W)) u_side (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (accept),
      .advance (fire),
      .keep    (keep_v[s]),
      .mask    (mask_q),
      .vl      (vl_q),
      .found   (found_v[s]),
      .pos     (pos_v[s]),
      .zero    (zero_v[s])
    );
  end

  assign both_found = &found_v;
  assign out_valid  = active_q && both_found;
  assign done       = active_q && !both_found;
  assign accept     = start && (!active_q || done);
  assign fire       = out_valid && out_ready;

  assign src_step = pos_v[SIDE_SRC];
  assign dst_step = pos_v[SIDE_DST];
  assign zero_src = out_valid && zero_v[SIDE_SRC];
  assign zero_dst = out_valid && zero_v[SIDE_DST];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      vl_q     <= '0;
      mask_q   <= '0;
      sz_q     <= 1'b0;
      dz_q     <= 1'b0;
    end else if (accept) begin
      active_q <= 1'b1;
      vl_q     <= LEN_W'(fit_len(int'(vl_in), MAX_VL));
      mask_q   <= pred_en ? mask_in : {MAX_VL{1'b1}};
      sz_q     <= sz;
      dz_q     <= dz;
    end else if (done) begin
      active_q <= 1'b0;
    end
  end

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(src_step) && $stable(dst_step)));

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (!done && !out_valid));

  // R9
  lockstep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (sz_q == dz_q)) |-> (src_step == dst_step));

  // R3
  ascending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (!out_valid || ((src_step > $past(src_step)) && (dst_step > $past(dst_step)))));
endmodule

// File: tb/tb_step_seq.sv
module tb_step_seq;
  localparam int CLK_PERIOD = 10;
  localparam int MAXV = 8;
  localparam int IW = $clog2(MAXV);
  localparam int LW = $clog2(MAXV + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [LW-1:0] vl_in = '0;
  logic pred_en = 1'b1;
  logic [MAXV-1:0] mask_in = '0;
  logic sz = 1'b0, dz = 1'b0;
  logic out_valid, out_ready = 1'b0;
  logic [IW-1:0] src_step, dst_step;
  logic zero_src, zero_dst, done;

  step_seq #(.MAX_VL(MAXV)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .vl_in(vl_in), .pred_en(pred_en),
    .mask_in(mask_in), .sz(sz), .dz(dz), .out_valid(out_valid), .out_ready(out_ready),
    .src_step(src_step), .dst_step(dst_step), .zero_src(zero_src), .zero_dst(zero_dst),
    .done(done)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  int es[MAXV], ed[MAXV], ezs[MAXV], ezd[MAXV];
  int np;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Expected schedule from the requirements (R4, R5, R6, R11).
  task automatic build(input int vl, input logic [MAXV-1:0] m, input bit pen, input bit s, input bit d);
    int evl, ns, nd;
    logic [MAXV-1:0] mf;
    evl = (vl > MAXV) ? MAXV : vl;
    mf = pen ? m : '1;
    ns = 0; nd = 0;
    for (int i = 0; i < evl; i++) begin
      if (s || mf[i]) begin es[ns] = i; ezs[ns] = (s && !mf[i]) ? 1 : 0; ns++; end
      if (d || mf[i]) begin ed[nd] = i; ezd[nd] = (d && !mf[i]) ? 1 : 0; nd++; end
    end
    np = (ns < nd) ? ns : nd;
  endtask

  task automatic run(input int vl, input logic [MAXV-1:0] m, input bit pen,
                     input bit s, input bit d, input bit stall);
    int k, cyc;
    build(vl, m, pen, s, d);
    @(negedge clk);
    start = 1'b1; vl_in = LW'(vl); mask_in = m; pred_en = pen; sz = s; dz = d;
    @(negedge clk);
    // R2: scramble captured inputs after start
    start = 1'b0; vl_in = ~vl_in; mask_in = ~m; pred_en = ~pen; sz = ~s; dz = ~d;
    k = 0;
    for (cyc = 0; cyc < 4 * MAXV + 8; cyc++) begin
      out_ready = stall ? ((cyc % 3) != 1) : 1'b1;
      #1;
      if (done) begin
        check(k == np, "R7", "pairs before done", k, np);
        check(!out_valid, "R7", "valid during done", int'(out_valid), 0);
        break;
      end
      check(out_valid && k < np, "R3", "valid pair expected", k, np);
      if (out_valid && k < np) begin
        check(int'(src_step) == es[k], "R4/R5 R2", "src_step", int'(src_step), es[k]);
        check(int'(dst_step) == ed[k], "R4/R5 R2", "dst_step", int'(dst_step), ed[k]);
        check(int'(zero_src) == ezs[k], "R5", "zero_src", int'(zero_src), ezs[k]);
        check(int'(zero_dst) == ezd[k], "R5", "zero_dst", int'(zero_dst), ezd[k]);
        if (s == d) check(src_step == dst_step, "R9", "lockstep", int'(src_step), int'(dst_step));
        if (out_ready) k++;
      end
      @(negedge clk);
    end
    out_ready = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL R7 watchdog cycles actual %0d expected below %0d", 190000, 190000);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (2) @(negedge clk);
    check(!out_valid, "R1", "out_valid in reset", int'(out_valid), 0);
    check(!done, "R1", "done in reset", int'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!out_valid && !done, "R1", "idle after reset", int'(out_valid) + int'(done), 0);

    // Worked schedules: mask 1101 with each flag pairing
    run(4, 8'b0000_1101, 1'b1, 1'b0, 1'b0, 1'b0);
    run(4, 8'b0000_1101, 1'b1, 1'b0, 1'b1, 1'b0);
    run(4, 8'b0000_1101, 1'b1, 1'b1, 1'b0, 1'b1);
    // R6: no predicate means all ones
    run(6, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0);
    // R11: oversized lengths clamp to MAXV
    run(12, 8'hFF, 1'b1, 1'b0, 1'b0, 1'b0);
    run(15, 8'hA5, 1'b1, 1'b1, 1'b0, 1'b1);
    // R7: zero length
    run(0, 8'hFF, 1'b1, 1'b1, 1'b1, 1'b0);

    // R10: start in the done cycle chains a new sequence with no gap
    @(negedge clk);
    start = 1'b1; vl_in = 4'd2; mask_in = 8'hFF; pred_en = 1'b1; sz = 1'b0; dz = 1'b0;
    out_ready = 1'b1;
    @(negedge clk); start = 1'b0;
    @(negedge clk); #1;
    check(out_valid && src_step == 3'd1, "R10", "second pair of first run", int'(src_step), 1);
    @(negedge clk); #1;
    check(done, "R10", "done of first run", int'(done), 1);
    start = 1'b1; vl_in = 4'd3; mask_in = 8'b0000_0101; sz = 1'b0; dz = 1'b0;
    @(negedge clk); start = 1'b0; #1;
    check(out_valid && !done, "R10", "chained run valid", int'(out_valid), 1);
    check(src_step == 3'd0 && dst_step == 3'd0, "R10", "chained first src", int'(src_step), 0);
    @(negedge clk); #1;
    check(out_valid && src_step == 3'd2 && dst_step == 3'd2, "R10", "chained second src", int'(src_step), 2);
    @(negedge clk); #1;
    check(done, "R10", "chained done", int'(done), 1);
    out_ready = 1'b0;

    // R10: start during a stalled pair is ignored
    @(negedge clk);
    start = 1'b1; vl_in = 4'd4; mask_in = 8'hFF; sz = 1'b0; dz = 1'b0;
    @(negedge clk);
    start = 1'b1; vl_in = 4'd1; mask_in = 8'h00; sz = 1'b1; dz = 1'b0; out_ready = 1'b0;
    #1;
    check(out_valid && src_step == 3'd0, "R8", "stalled pair", int'(src_step), 0);
    @(negedge clk); start = 1'b0; out_ready = 1'b1; #1;
    check(out_valid && src_step == 3'd0 && !zero_src, "R10", "ignored start keeps pair", int'(src_step), 0);
    for (int j = 1; j < 4; j++) begin
      @(negedge clk); #1;
      check(out_valid && int'(src_step) == j && int'(dst_step) == j, "R10", "old sequence continues", int'(src_step), j);
    end
    @(negedge clk); #1;
    check(done, "R10", "old sequence ends at 4", int'(done), 1);
    out_ready = 1'b0;

    // Sweep: every length, every mask, every flag pair (R3 R4 R5 R8 R9)
    for (int v = 0; v <= MAXV; v++) begin
      for (int m = 0; m < 256; m++) begin
        for (int f = 0; f < 4; f++) begin
          run(v, 8'(m), 1'b1, f[0], f[1], (m % 5) == 0);
        end
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule